// File: doc/BRIEF.md
# Pin interrupt register block

This block holds the control and status words of a 32-pin interrupt controller and presents them on a simple word-addressed bus. The bus carries a byte offset, write data, an access size in bytes, separate read and write strobes, registered read data and an error flag. Three control words (mask, edge select and polarity invert) have no direct address. Software changes each one through a pair of aliases: one sets bits and the other clears them. Either alias reads back the stored word. Four further words (request, pin assignment, pin state and latch) are plain read/write storage.

The mask, edge and invert words leave the block as 32-bit outputs for the pin-sampling and edge-detection logic next to it. That logic is not part of this block. An instance-number parameter sets the reset value of the pin assignment word. Illegal accesses are refused with an error and change nothing.

The block has no sequencing of its own, so it has no state machine. Each access is decoded and completed in the cycle of its strobe. The only sequential parts are the stored words and the read-data register.

Top module: `pin_irq_regs`

## Requirements
- R1: The word at byte offset 0x08 (request), 0x0C (pin assignment), 0x20 (pin state) or 0x24 (latch) stores a valid write unchanged and returns it on a later read.
- R2: Offsets 0x00 and 0x04 both read the mask word. Offsets 0x10 and 0x14 both read the edge word. Offsets 0x18 and 0x1C both read the invert word. Each of these words also appears on its output port (`mask_o`, `edge_o`, `invert_o`).
- R3: A write to a set alias (0x00, 0x10, 0x18) ORs the data into its word. A write to a clear alias (0x04, 0x14, 0x1C) clears every word bit whose data bit is 1. Zero data bits leave the stored bits unchanged.
- R4: After reset the mask, edge, invert, request, pin state and latch words are all zero.
- R5: After reset the pin assignment word depends on the parameter `INST`: 0x00000101 for 0 and 2, 0x01010000 for 1, 0x02020303 for 3, and 0 for any other value.
- R6: A read or write whose `bus_size` is not 4 raises `bus_err` in the same cycle as its strobe and updates no word. This holds at mapped offsets too.
- R7: A read or write at an offset that is not a multiple of 4, or that lies at 0x28 or above, raises `bus_err` in the same cycle and updates no word.
- R8: Read data appears on `bus_rdata` in the cycle after the read strobe and is held until the next read. A read flagged with an error returns zero.
- R9: The mask, edge and invert outputs change only in the cycle after an error-free write to one of their own aliases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_size | input | 3 | Access size in bytes |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Error response, same cycle as the strobe |
| mask_o | output | 32 | Stored mask word |
| edge_o | output | 32 | Stored edge-select word |
| invert_o | output | 32 | Stored invert word |

## Verification
`bus_err` is combinational, so the bench samples it one nanosecond after driving the strobe, in the same cycle. Read data passes through one register, so the bench samples it at the falling edge after the rising edge that follows the strobe. A write reaches the alias words at that same rising edge. The bench therefore checks the output ports and any read-back only from the following falling edge onward. Every refused write is followed by a read, or a look at the outputs, of the word it could have changed.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

    localparam int unsigned DATA_W     = 32;
    localparam int unsigned WORD_BYTES = 4;
    localparam int unsigned NUM_REGS   = 10;
    localparam int unsigned ALIAS_N    = 3;
    localparam int unsigned PLAIN_N    = 4;

    // register index = byte offset / 4; order is the bus map
    typedef enum logic [3:0] {
        SEL_MASK_SET = 4'd0,
        SEL_MASK_CLR = 4'd1,
        SEL_REQUEST  = 4'd2,
        SEL_ASSIGN   = 4'd3,
        SEL_EDGE_SET = 4'd4,
        SEL_EDGE_CLR = 4'd5,
        SEL_INV_SET  = 4'd6,
        SEL_INV_CLR  = 4'd7,
        SEL_PINSTATE = 4'd8,
        SEL_LATCH    = 4'd9,
        SEL_NONE     = 4'd15
    } reg_sel_e;

    function automatic logic [DATA_W-1:0] assign_reset(input int unsigned inst);
        case (inst)
            0, 2:    return 32'h0000_0101;
            1:       return 32'h0101_0000;
            3:       return 32'h0202_0303;
            default: return '0;
        endcase
    endfunction

    function automatic reg_sel_e alias_set_sel(input int unsigned idx);
        case (idx)
            0:       return SEL_MASK_SET;
            1:       return SEL_EDGE_SET;
            default: return SEL_INV_SET;
        endcase
    endfunction

    function automatic reg_sel_e alias_clr_sel(input int unsigned idx);
        case (idx)
            0:       return SEL_MASK_CLR;
            1:       return SEL_EDGE_CLR;
            default: return SEL_INV_CLR;
        endcase
    endfunction

    function automatic reg_sel_e plain_sel(input int unsigned idx);
        case (idx)
            0:       return SEL_REQUEST;
            1:       return SEL_ASSIGN;
            2:       return SEL_PINSTATE;
            default: return SEL_LATCH;
        endcase
    endfunction

endpackage

// File: rtl/pin_irq_decode.sv
module pin_irq_decode
    import pin_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    input  logic              rd,
    input  logic              wr,
    output reg_sel_e          sel,
    output logic              err
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             mapped;
    logic             size_ok;

    assign idx     = addr[ADDR_W-1:2];
    assign mapped  = (addr[1:0] == 2'b00) && (idx < IDX_W'(NUM_REGS));
    assign size_ok = (size == 3'(WORD_BYTES));

    always_comb begin
        if (mapped) sel = reg_sel_e'(idx[3:0]);
        else        sel = SEL_NONE;
    end

    // size fault checked first; either fault alone refuses the access
    assign err = (rd | wr) & (!size_ok | !mapped);
endmodule

// File: rtl/pin_irq_alias_word.sv
module pin_irq_alias_word #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= '0;
        else if (set_we) q <= q | wdata;
        else if (clr_we) q <= q & ~wdata;
    end
endmodule

// File: rtl/pin_irq_plain_word.sv
module pin_irq_plain_word #(
    parameter int unsigned W       = 32,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= RST_VAL;
        else if (we) q <= wdata;
    end
endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
    import pin_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned INST   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [2:0]        bus_size,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    output logic [31:0]       mask_o,
    output logic [31:0]       edge_o,
    output logic [31:0]       invert_o
);
    reg_sel_e          sel;
    logic              wr_ok;
    logic [DATA_W-1:0] alias_q [ALIAS_N];
    logic [DATA_W-1:0] plain_q [PLAIN_N];
    logic [DATA_W-1:0] rd_mux;

    pin_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .size (bus_size),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .sel  (sel),
        .err  (bus_err)
    );

    assign wr_ok = bus_wr & ~bus_err;

    for (genvar g = 0; g < ALIAS_N; g++) begin : g_alias
        localparam reg_sel_e SET_SEL = alias_set_sel(g);
        localparam reg_sel_e CLR_SEL = alias_clr_sel(g);
        pin_irq_alias_word #(.W(DATA_W)) u_word (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_we (wr_ok && (sel == SET_SEL)),
            .clr_we (wr_ok && (sel == CLR_SEL)),
            .wdata  (bus_wdata),
            .q      (alias_q[g])
        );
    end

    for (genvar g = 0; g < PLAIN_N; g++) begin : g_plain
        localparam reg_sel_e SEL = plain_sel(g);
        localparam logic [DATA_W-1:0] RV = (g == 1) ? assign_reset(INST) : '0;
        pin_irq_plain_word #(.W(DATA_W), .RST_VAL(RV)) u_word (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_ok && (sel == SEL)),
            .wdata (bus_wdata),
            .q     (plain_q[g])
        );
    end

    always_comb begin
        unique case (sel)
            SEL_MASK_SET, SEL_MASK_CLR: rd_mux = alias_q[0];
            SEL_EDGE_SET, SEL_EDGE_CLR: rd_mux = alias_q[1];
            SEL_INV_SET,  SEL_INV_CLR:  rd_mux = alias_q[2];
            SEL_REQUEST:                rd_mux = plain_q[0];
            SEL_ASSIGN:                 rd_mux = plain_q[1];
            SEL_PINSTATE:               rd_mux = plain_q[2];
            SEL_LATCH:                  rd_mux = plain_q[3];
            default:                    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= bus_err ? '0 : rd_mux;
    end

    assign mask_o   = alias_q[0];
    assign edge_o   = alias_q[1];
    assign invert_o = alias_q[2];
endmodule

// File: rtl/pin_irq_regs_chk.sv
module pin_irq_regs_chk #(
    parameter int unsigned ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [2:0]        bus_size,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [31:0]       bus_rdata,
    input logic              bus_err,
    input logic [31:0]       mask_o,
    input logic [31:0]       edge_o,
    input logic [31:0]       invert_o
);
    AST_SIZE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && bus_size != 3'd4) |-> bus_err); // R6

    AST_UNMAPPED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && (bus_addr >= ADDR_W'(40) || bus_addr[1:0] != 2'b00)) |-> bus_err); // R7

    AST_BAD_WR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_err) |=> ($stable(mask_o) && $stable(edge_o) && $stable(invert_o))); // R6

    AST_SET_NEVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_err && bus_addr == ADDR_W'(0)) |=> ((mask_o & $past(mask_o)) == $past(mask_o))); // R3

    AST_CLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_err && bus_addr == ADDR_W'(4)) |=> ((mask_o & $past(bus_wdata)) == 32'd0)); // R3

    AST_NO_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr) |=> ($stable(mask_o) && $stable(edge_o) && $stable(invert_o))); // R9

    AST_ERR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_err) |=> (bus_rdata == 32'd0)); // R8

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd) |=> $stable(bus_rdata)); // R8
endmodule

bind pin_irq_regs pin_irq_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_size  (bus_size),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .mask_o    (mask_o),
    .edge_o    (edge_o),
    .invert_o  (invert_o)
);

// File: tb/pin_irq_regs_bench.sv
`timescale 1ns/1ps
module pin_irq_regs_bench;
    localparam int ADDR_W = 6;

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [5:0]  addr;
        logic [2:0]  size;
        logic [31:0] wdata;
        logic        exp_err;
        logic [31:0] exp_rdata;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 6'h0C, 3'd4, 32'h0,          1'b0, 32'h0202_0303}, // R5
        '{1'b1, 1'b0, 6'h00, 3'd4, 32'h0000_00F0, 1'b0, 32'h0},          // R3 set
        '{1'b1, 1'b0, 6'h00, 3'd4, 32'h0000_0F00, 1'b0, 32'h0},          // R3 set
        '{1'b0, 1'b1, 6'h04, 3'd4, 32'h0,          1'b0, 32'h0000_0FF0}, // R2
        '{1'b1, 1'b0, 6'h04, 3'd4, 32'h0000_0030, 1'b0, 32'h0},          // R3 clear
        '{1'b0, 1'b1, 6'h00, 3'd4, 32'h0,          1'b0, 32'h0000_0FC0}, // R3
        '{1'b1, 1'b0, 6'h10, 3'd4, 32'hA5A5_0000, 1'b0, 32'h0},
        '{1'b0, 1'b1, 6'h14, 3'd4, 32'h0,          1'b0, 32'hA5A5_0000}, // R2
        '{1'b1, 1'b0, 6'h18, 3'd4, 32'hFFFF_FFFF, 1'b0, 32'h0},
        '{1'b1, 1'b0, 6'h1C, 3'd4, 32'h0000_FFFF, 1'b0, 32'h0},
        '{1'b0, 1'b1, 6'h18, 3'd4, 32'h0,          1'b0, 32'hFFFF_0000}, // R3
        '{1'b1, 1'b0, 6'h08, 3'd4, 32'h1234_5678, 1'b0, 32'h0},
        '{1'b0, 1'b1, 6'h08, 3'd4, 32'h0,          1'b0, 32'h1234_5678}, // R1
        '{1'b1, 1'b0, 6'h0C, 3'd4, 32'h1122_3344, 1'b0, 32'h0},
        '{1'b0, 1'b1, 6'h0C, 3'd4, 32'h0,          1'b0, 32'h1122_3344}, // R1
        '{1'b1, 1'b0, 6'h20, 3'd4, 32'hDEAD_BEEF, 1'b0, 32'h0},
        '{1'b0, 1'b1, 6'h20, 3'd4, 32'h0,          1'b0, 32'hDEAD_BEEF}, // R1
        '{1'b1, 1'b0, 6'h24, 3'd4, 32'h0BAD_F00D, 1'b0, 32'h0},
        '{1'b0, 1'b1, 6'h24, 3'd4, 32'h0,          1'b0, 32'h0BAD_F00D}, // R1
        '{1'b0, 1'b1, 6'h08, 3'd2, 32'h0,          1'b1, 32'h0},          // R6, R8
        '{1'b0, 1'b1, 6'h2C, 3'd4, 32'h0,          1'b1, 32'h0},          // R7, R8
        '{1'b0, 1'b1, 6'h06, 3'd4, 32'h0,          1'b1, 32'h0}           // R7
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [2:0]        bus_size = 3'd4;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [31:0]       rdata3, rdata1, rdata2;
    logic              err3, err1, err2;
    logic [31:0]       mask3, edge3, inv3;
    logic [31:0]       m1, e1, i1, m2, e2, i2;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic        s_err;
    logic [31:0] s_rdata;

    always #5 clk = ~clk;

    pin_irq_regs #(.ADDR_W(ADDR_W), .INST(3)) u_pin_irq_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_size(bus_size), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(rdata3), .bus_err(err3),
        .mask_o(mask3), .edge_o(edge3), .invert_o(inv3));

    pin_irq_regs #(.ADDR_W(ADDR_W), .INST(1)) u_alt1 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_size(bus_size), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(rdata1), .bus_err(err1),
        .mask_o(m1), .edge_o(e1), .invert_o(i1));

    pin_irq_regs #(.ADDR_W(ADDR_W), .INST(2)) u_alt2 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_size(bus_size), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(rdata2), .bus_err(err2),
        .mask_o(m2), .edge_o(e2), .invert_o(i2));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at falling edge; err sampled 1 ns later; rdata at next falling edge
    task automatic access(input logic wr, input logic rd, input logic [5:0] addr,
                          input logic [2:0] size, input logic [31:0] wdata);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = addr; bus_size = size; bus_wdata = wdata;
        #1 s_err = err3;
        @(negedge clk);
        s_rdata = rdata3;
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state
        check("R4 mask", mask3, 32'h0);
        check("R4 edge", edge3, 32'h0);
        check("R4 invert", inv3, 32'h0);
        check("R8 rdata reset", rdata3, 32'h0);
        access(0, 1, 6'h08, 3'd4, 0); check("R4 request", s_rdata, 32'h0);
        access(0, 1, 6'h20, 3'd4, 0); check("R4 pinstate", s_rdata, 32'h0);
        access(0, 1, 6'h24, 3'd4, 0); check("R4 latch", s_rdata, 32'h0);
        access(0, 1, 6'h0C, 3'd4, 0);
        check("R5 inst1", rdata1, 32'h0101_0000);
        check("R5 inst2", rdata2, 32'h0000_0101);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].rd, VECS[i].addr, VECS[i].size, VECS[i].wdata);
            check($sformatf("R6/R7 err vec%0d", i), 32'(s_err), 32'(VECS[i].exp_err));
            if (VECS[i].rd)
                check($sformatf("R1/R2/R3 rdata vec%0d", i), s_rdata, VECS[i].exp_rdata);
        end

        // R2 ports follow stored words
        check("R2 mask_o", mask3, 32'h0000_0FC0);
        check("R2 edge_o", edge3, 32'hA5A5_0000);
        check("R2 invert_o", inv3, 32'hFFFF_0000);

        // R6 refused write of wrong size leaves mask
        access(1, 0, 6'h00, 3'd2, 32'hFFFF_FFFF);
        check("R6 err", 32'(s_err), 32'd1);
        check("R6 mask kept", mask3, 32'h0000_0FC0);
        access(1, 0, 6'h08, 3'd1, 32'h0);
        access(0, 1, 6'h08, 3'd4, 0);
        check("R6 request kept", s_rdata, 32'h1234_5678);

        // R7 unmapped and misaligned writes change nothing
        access(1, 0, 6'h28, 3'd4, 32'hFFFF_FFFF);
        check("R7 err 0x28", 32'(s_err), 32'd1);
        access(1, 0, 6'h05, 3'd4, 32'hFFFF_FFFF);
        check("R7 err misaligned", 32'(s_err), 32'd1);
        check("R7 mask kept", mask3, 32'h0000_0FC0);
        check("R7 invert kept", inv3, 32'hFFFF_0000);
        access(0, 1, 6'h24, 3'd4, 0);
        check("R7 latch kept", s_rdata, 32'h0BAD_F00D);

        // R9 write to another word leaves alias outputs
        access(1, 0, 6'h20, 3'd4, 32'h0);
        check("R9 mask hold", mask3, 32'h0000_0FC0);
        check("R9 edge hold", edge3, 32'hA5A5_0000);

        // R3 zero data bits leave word; clear with all ones empties
        access(1, 0, 6'h10, 3'd4, 32'h0);
        check("R3 set zero", edge3, 32'hA5A5_0000);
        access(1, 0, 6'h14, 3'd4, 32'hFFFF_FFFF);
        check("R3 clear all", edge3, 32'h0);

        // R8 rdata held after read with no further read
        access(0, 1, 6'h18, 3'd4, 0);
        @(negedge clk); @(negedge clk);
        check("R8 hold", rdata3, 32'hFFFF_0000);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule